// File: doc/BRIEF.md
# Logic Self-Test Wrapper with Inversion Test Points

This block wraps a small combinational circuit under test (CUT) with the parts it needs to test itself. These parts are a pseudo-random pattern source, an input multiplexer, a signature compactor and a session controller. The CUT has a 32-input OR whose output reaches a 32-input AND. With random inputs the OR output is almost always 1, so a stuck-at-1 fault on that net is very hard to detect. An inversion test point sits on that net. When it is enabled it complements the net, so the net keeps toggling with the patterns and is not clamped to a constant. The CUT also has one force-to-0 point, one force-to-1 point and one observe tap. A single test-point enable controls all of the points.

In functional mode the CUT takes `func_in`, and all test points are inactive. A `start` pulse begins a session of `SESSION_LEN` patterns. The points are off for the first half of the session and on for the second half. Every response is folded into a 16-bit signature. At the end, `done` rises and `pass` reports whether the signature equals the parameter `GOLDEN`.

Top module: `lbist_inv_tp`

## Requirements
- R1: When no session is running, the CUT input is `func_in` and the test-point enable is low. With input x, the outputs are defined as follows. Let or_n = OR of x[31:0] and inv_n = or_n XOR tpe. Then func_out[0] = inv_n AND x[31] AND ... AND x[1]; func_out[1] = ((x[0]^x[1]) AND NOT tpe) OR x[4]; func_out[2] = ((x[2] AND x[3]) OR tpe) XOR x[5]; func_out[3] = inv_n XOR x[6].
- R2: A `start` seen at a clock edge while idle or done loads the generator seed and clears the signature. `busy` is high from the next cycle. A `start` while busy has no effect.
- R3: The pattern generator is a 32-bit right-shifting Galois LFSR. Each step computes next = (s>>1) XOR (s[0] ? LFSR_MASK : 0). The default mask is 32'h80200003 and the default non-zero seed is 32'hACE12468. Pattern k of a session is the seed stepped k times.
- R4: A session applies exactly `SESSION_LEN` patterns, one per cycle. The test-point enable is low for patterns 0 to SESSION_LEN/2-1 and high for the rest.
- R5: Force-to-0 point: while tpe is high, the net x[0]^x[1] is replaced by 0.
- R6: Force-to-1 point: while tpe is high, the net x[2] AND x[3] is replaced by 1.
- R7: Inversion point: while tpe is high, the OR net is complemented, both where it feeds the AND and where it feeds func_out[3].
- R8: Observe tap: the parity of x[15:8] enters the compactor at bit 4 and does not change `func_out`.
- R9: The compactor input is {11'b0, parity, func_out[3:0]}. Each pattern updates the signature as sig = (sig<<1) XOR (sig[15] ? MISR_POLY : 0) XOR input. The default polynomial is 16'h1021.
- R10: After the last pattern, `done` is high, `busy` is low and `signature` is held. `pass` is high exactly when done and signature == GOLDEN.
- R11: After reset, `busy`, `done` and `pass` are 0 and `signature` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a self-test session |
| func_in | input | 32 | Functional inputs of the CUT |
| func_out | output | 4 | CUT outputs |
| busy | output | 1 | Session in progress |
| done | output | 1 | Session finished |
| pass | output | 1 | Final signature equals GOLDEN |
| signature | output | 16 | Compactor contents |

## Verification
The assertions check on every cycle that the enable stays low outside a session and that it rises exactly at the half-way pattern. They also check that a start during a session leaves the count advancing, that the generator never reaches zero, and that a finished result stays frozen and `pass` only appears with `done`. Only the bench scenarios can show that each forced, inverted and tapped net gives the right output values. They also show that the per-pattern responses match an independent model in both halves, and that the final signature and the pass verdict agree with a golden value that matches or deliberately differs.

// File: rtl/lbist_inv_tp.sv
module lbist_inv_tp #(
  parameter int          SIG_W       = 16,
  parameter int          SESSION_LEN = 65536,
  parameter logic [31:0] LFSR_SEED   = 32'hACE12468,
  parameter logic [31:0] LFSR_MASK   = 32'h80200003,
  parameter logic [SIG_W-1:0] MISR_POLY = 16'h1021,
  parameter logic [SIG_W-1:0] GOLDEN    = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [31:0]      func_in,
  output logic [3:0]       func_out,
  output logic             busy,
  output logic             done,
  output logic             pass,
  output logic [SIG_W-1:0] signature
);
  localparam int CNT_W = $clog2(SESSION_LEN);
  localparam int HALF  = SESSION_LEN / 2;
  localparam int RSP_W = 5;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} st_t;
  st_t st;

  logic [31:0]      lfsr;
  logic [CNT_W-1:0] cnt;
  logic [SIG_W-1:0] sig;

  logic        test_mode, tpe;
  logic [31:0] x;
  logic        or_n, inv_n, c0_n, c1_n, obs_n;
  logic [RSP_W-1:0] resp;
  logic [SIG_W-1:0] misr_next;
  logic [31:0]      lfsr_next;

  assign test_mode = (st == S_RUN);
  assign tpe       = test_mode && (cnt >= CNT_W'(HALF));
  assign x         = test_mode ? lfsr : func_in;

  assign or_n  = |x;
  assign inv_n = or_n ^ tpe;
  assign c0_n  = (x[0] ^ x[1]) & ~tpe;
  assign c1_n  = (x[2] & x[3]) | tpe;
  assign obs_n = ^x[15:8];

  assign func_out[0] = inv_n & (&x[31:1]);
  assign func_out[1] = c0_n | x[4];
  assign func_out[2] = c1_n ^ x[5];
  assign func_out[3] = inv_n ^ x[6];

  assign resp      = {obs_n, func_out};
  assign misr_next = {sig[SIG_W-2:0], 1'b0} ^ (sig[SIG_W-1] ? MISR_POLY : '0)
                   ^ {{(SIG_W-RSP_W){1'b0}}, resp};
  assign lfsr_next = (lfsr >> 1) ^ (lfsr[0] ? LFSR_MASK : 32'h0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      lfsr <= LFSR_SEED;
      cnt  <= '0;
      sig  <= '0;
    end else begin
      case (st)
        S_RUN: begin
          sig  <= misr_next;
          lfsr <= lfsr_next;
          cnt  <= cnt + 1'b1;
          if (cnt == CNT_W'(SESSION_LEN - 1)) st <= S_FIN;
        end
        default: if (start) begin
          st   <= S_RUN;
          lfsr <= LFSR_SEED;
          cnt  <= '0;
          sig  <= '0;
        end
      endcase
    end
  end

  assign busy      = test_mode;
  assign done      = (st == S_FIN);
  assign pass      = done && (sig == GOLDEN);
  assign signature = sig;
endmodule

// File: rtl/lbist_inv_tp_chk.sv
module lbist_inv_tp_chk #(
  parameter int SIG_W       = 16,
  parameter int SESSION_LEN = 65536,
  localparam int CNT_W = $clog2(SESSION_LEN)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             pass,
  input logic             tpe,
  input logic [31:0]      lfsr,
  input logic [CNT_W-1:0] cnt,
  input logic [SIG_W-1:0] signature
);
  a_r1_no_tp_outside: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tpe);

  a_r4_tpe_at_half: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tpe) |-> (cnt == CNT_W'(SESSION_LEN / 2)));

  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && cnt == '0 && signature == '0));

  a_r2_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && cnt != CNT_W'(SESSION_LEN - 1)) |=>
      (busy && cnt == $past(cnt) + 1'b1));

  a_r3_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (lfsr != 32'h0));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(signature)));

  a_r10_pass_done: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> (done && !busy));
endmodule

bind lbist_inv_tp lbist_inv_tp_chk #(.SIG_W(SIG_W), .SESSION_LEN(SESSION_LEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .pass(pass), .tpe(tpe), .lfsr(lfsr), .cnt(cnt), .signature(signature)
);

// File: tb/lbist_inv_tp_tb_top.sv
module lbist_inv_tp_tb_top;
  localparam int LEN = 256;
  localparam logic [31:0] SEED = 32'hACE12468;
  localparam logic [31:0] MASK = 32'h80200003;
  localparam logic [15:0] POLY = 16'h1021;

  function automatic logic [31:0] m_step(input logic [31:0] s);
    return (s >> 1) ^ (s[0] ? MASK : 32'h0);
  endfunction

  function automatic logic [4:0] m_resp(input logic [31:0] x, input logic t);
    logic o, iv;
    logic [3:0] y;
    o    = |x;
    iv   = o ^ t;
    y[0] = iv & (&x[31:1]);
    y[1] = ((x[0] ^ x[1]) & ~t) | x[4];
    y[2] = ((x[2] & x[3]) | t) ^ x[5];
    y[3] = iv ^ x[6];
    return {^x[15:8], y};
  endfunction

  function automatic logic [15:0] m_misr(input logic [15:0] s, input logic [4:0] d);
    return {s[14:0], 1'b0} ^ (s[15] ? POLY : 16'h0) ^ {11'b0, d};
  endfunction

  function automatic logic [15:0] m_gold();
    logic [31:0] x;
    logic [15:0] s;
    x = SEED;
    s = '0;
    for (int i = 0; i < LEN; i++) begin
      s = m_misr(s, m_resp(x, i >= LEN / 2));
      x = m_step(x);
    end
    return s;
  endfunction

  localparam logic [15:0] GOLD = m_gold();

  // {func_in, expected func_out} in functional mode (R1, R8)
  localparam logic [35:0] FVEC [9] = '{
    {32'h0000_0000, 4'b0000}, {32'hFFFF_FFFF, 4'b0011},
    {32'h0000_0001, 4'b1010}, {32'h0000_000C, 4'b1100},
    {32'h0000_0040, 4'b0000}, {32'hFFFF_FFFE, 4'b0011},
    {32'h0000_0030, 4'b1110}, {32'h0000_0100, 4'b1000},
    {32'h0000_0300, 4'b1000}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0] func_in = '0;
  logic [3:0]  func_out, fo_bad;
  logic busy, done, pass, busy_b, done_b, pass_b;
  logic [15:0] signature, sig_b;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  lbist_inv_tp #(.SESSION_LEN(LEN), .GOLDEN(GOLD)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .func_in(func_in),
    .func_out(func_out), .busy(busy), .done(done), .pass(pass), .signature(signature));

  lbist_inv_tp #(.SESSION_LEN(LEN), .GOLDEN(GOLD ^ 16'h0001)) dut_bad_i (
    .clk(clk), .rst_n(rst_n), .start(start), .func_in(func_in),
    .func_out(fo_bad), .busy(busy_b), .done(done_b), .pass(pass_b), .signature(sig_b));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic session(input bit poke_start);
    logic [31:0] mx;
    logic [15:0] ms;
    logic [4:0]  r;
    int bad;
    mx  = SEED;
    ms  = '0;
    bad = 0;
    @(negedge clk); start = 1'b1;
    for (int i = 0; i < LEN; i++) begin
      @(negedge clk);
      start = poke_start && (i == 10);
      r = m_resp(mx, i >= LEN / 2);
      // R3 R4 R5 R6 R7: per-pattern outputs in both halves
      if (!busy || func_out !== r[3:0]) begin
        bad++;
        if (bad < 4) chk(1'b0, "R4/R5/R6/R7 pattern output", {27'b0, busy, func_out}, {28'b1, r[3:0]});
      end
      ms = m_misr(ms, r);
      mx = m_step(mx);
    end
    chk(bad == 0, "R4 all patterns matched", bad, 0);
    @(negedge clk);
    chk(done && !busy, "R10 done after LEN", {busy, done}, 2'b01);
    chk(signature == ms, "R9 signature", signature, ms);
    chk(pass == 1'b1, "R10 pass on golden", pass, 1);
    chk(pass_b == 1'b0 && done_b, "R10 no pass on wrong golden", pass_b, 0);
    if (poke_start) chk(signature == GOLD, "R2 start while busy ignored", signature, GOLD);
    repeat (3) @(negedge clk);
    chk(signature == ms && done, "R10 signature held", signature, ms);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !pass && signature == 16'h0, "R11 reset state",
        {busy, done, pass, signature}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R11 idle after reset", {busy, done}, 0);
    foreach (FVEC[k]) begin
      func_in = FVEC[k][35:4];
      #1;
      chk(func_out == FVEC[k][3:0], "R1/R8 functional output", func_out, FVEC[k][3:0]);
    end
    session(1'b0);
    func_in = 32'h0000_0001;
    #1;
    chk(func_out == 4'b1010, "R1 functional after done", func_out, 4'b1010);
    session(1'b1);
    chk(m_step(SEED) == 32'h5670_9234 ^ 32'h0, "R3 model step sanity", m_step(SEED), 32'h5670_9234);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule